// File: doc/BRIEF.md
# SD Command Response Capture Unit

This block sits behind the command line of an SD/MMC host. After the command sender reports that a command has left the host, the unit watches the command line for the card's reply, one bit per card-clock strobe. A 2-bit type code, given with the command, says whether a reply is expected, how long it is and whether its CRC7 must be checked. The unit counts idle strobes and gives up after a programmable limit, so a missing card can never stall the host.

The bits are packed into 16-bit words while they arrive. The words go into a small FIFO that the host drains over a valid/ready stream. The transfer happens on a cycle with `rsp_valid` and `rsp_ready` both high. While `rsp_ready` is low the head word and `rsp_valid` hold. Words stay until they are read or until the next command is accepted, which discards them. A short reply yields three words and a long reply eight. Three sticky status flags (response finished, CRC error, timeout) sit at fixed bit positions of a status word and are cleared by writing ones.

Top module: `sd_resp_capture`

## Requirements
- R1: When `cmd_sent` is accepted with type 0 (no reply), status bit 13 is set on the next cycle and no word is produced. Types 1, 2 and 3 wait for a start bit, which is a 0 sampled on `cmd_line` while `bit_en` is high.
- R2: Types 1 and 3 take a 48-bit reply, counted from the start bit. All 48 bits come out as three 16-bit words, first-received bit in bit 15 of the first word. The 32-bit argument is then `w0<<24 | w1<<8 | w2>>8` (low 32 bits).
- R3: Type 2 takes a 136-bit reply. The first 8 bits (start, direction, six reserved) are dropped, and bits 8..135 come out as eight words in arrival order, most significant word first.
- R4: The CRC7 uses x^7+x^3+1 with a zero seed. For 48-bit replies it covers bits 0..39; for 136-bit replies it covers bits 8..127. It is compared with the next seven received bits, MSB first. A mismatch in any of those seven bits counts as an error.
- R5: Status bit 5 (CRC error) is set at the end of a reply only for types 1 and 2. A type 3 reply with a wrong CRC never sets it.
- R6: While waiting, each strobe with `cmd_line` high counts one idle tick. After L such ticks, where L is the timeout limit, status bit 1 and status bit 13 are set together and the capture ends. L is 0xFF after reset, is loaded by `tmo_we`, and a value of 0 acts as 1.
- R7: Status bit 13 is set in the cycle after the strobe that samples the last bit of a reply.
- R8: Writing `stat_clr_data` with `stat_clr_we` clears each status flag whose bit is 1 and leaves the others alone. If a flag is set and cleared in the same cycle, it ends up set. All other status bits read 0.
- R9: The word stream follows valid/ready. The head word and `rsp_valid` hold while `rsp_ready` is low. Words are kept until read, and accepting a new command discards unread words.
- R10: A `cmd_sent` pulse that arrives while a reply is awaited or being received is ignored. The capture in progress keeps its type.
- R11: After reset the status word is 0 and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe: sample `cmd_line` now (card-clock edge) |
| cmd_line | input | 1 | Command line level from the card |
| cmd_sent | input | 1 | Pulse: command transmission ended, start capture |
| resp_kind | input | 2 | Reply type: 0 none, 1 48-bit with CRC, 2 136-bit, 3 48-bit no CRC |
| tmo_we | input | 1 | Load the timeout limit |
| tmo_wdata | input | TMO_W | New timeout limit in idle strobes |
| stat_clr_we | input | 1 | Write-one-to-clear strobe for the status flags |
| stat_clr_data | input | 16 | Clear mask, same bit layout as `status_word` |
| status_word | output | 16 | Bit 13 end of reply, bit 5 CRC error, bit 1 timeout |
| rsp_valid | output | 1 | A reply word is available |
| rsp_ready | input | 1 | Host takes the word on this cycle |
| rsp_data | output | WORD_W | Head reply word |

## Verification
On every cycle, the bound checker checks the following. A timeout flag never appears without the end flag. A type-0 command raises the end flag on the next cycle. The head word holds under back-pressure, and the FIFO is never pushed while full. A write-one clear really drops the CRC flag, and the reserved status bits stay zero. The bench's scenarios are needed for the rest. Those are the word order and packing of both reply lengths, the CRC7 result for every corrupted check bit and for corrupted content, and the type-3 exemption. They also cover the exact idle-tick count before a timeout, the discard of stale words and the ignored mid-capture command. The bench computes all of these from its own CRC and bit-field arithmetic.

// File: rtl/sd_resp_pkg.sv
package sd_resp_pkg;

  typedef enum logic [1:0] {
    RK_NONE      = 2'd0,
    RK_SHORT_CRC = 2'd1,
    RK_LONG      = 2'd2,
    RK_SHORT_RAW = 2'd3
  } resp_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RECV = 2'd2
  } cap_state_e;

  // reply geometry, bit indices counted from the start bit
  localparam int SHORT_BITS    = 48;
  localparam int LONG_BITS     = 136;
  localparam int LONG_SKIP     = 8;
  localparam int SHORT_COV_END = 40;
  localparam int LONG_COV_END  = 128;
  localparam int CRC_LEN       = 7;

  // status word layout
  localparam int STAT_W       = 16;
  localparam int STAT_END_BIT = 13;
  localparam int STAT_CRC_BIT = 5;
  localparam int STAT_TMO_BIT = 1;

endpackage

// File: rtl/sd_crc_serial.sv
module sd_crc_serial #(
  parameter int             W    = 7,
  parameter logic [W-1:0]   POLY = 'h09
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  input  logic calc,
  input  logic din,
  output logic msb
);

  logic [W-1:0] rem_q;

  // calc: fold din into the remainder; otherwise shift the remainder out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (clear) begin
      rem_q <= '0;
    end else if (en) begin
      if (calc) rem_q <= {rem_q[W-2:0], 1'b0} ^ ((din ^ rem_q[W-1]) ? POLY : '0);
      else      rem_q <= {rem_q[W-2:0], 1'b0};
    end
  end

  assign msb = rem_q[W-1];

endmodule

// File: rtl/sd_word_pack.sv
module sd_word_pack #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bit_vld,
  input  logic              din,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign word_out = {sh_q[WORD_W-2:0], din};
  assign word_vld = bit_vld && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (bit_vld) begin
      sh_q  <= word_out;
      cnt_q <= word_vld ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sd_word_fifo.sv
module sd_word_fifo #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [WORD_W-1:0]          push_data,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic [WORD_W-1:0]          out_data,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              do_push, do_pop;

  assign full      = (lvl_q == LVL_FULL);
  assign out_valid = (lvl_q != '0);
  assign out_data  = mem_q[rd_q];
  assign level     = lvl_q;
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem_q[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      lvl_q <= lvl_q + 1'b1;
      else if (do_pop && !do_push) lvl_q <= lvl_q - 1'b1;
    end
  end

endmodule

// File: rtl/sd_resp_ctrl.sv
module sd_resp_ctrl
  import sd_resp_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             cmd_line,
  input  logic             cmd_sent,
  input  logic [1:0]       resp_kind,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             crc_msb,
  output logic             cmd_take,
  output logic             crc_en,
  output logic             crc_calc,
  output logic             pack_vld,
  output logic             set_end,
  output logic             set_crc,
  output logic             set_tmo
);

  localparam int IDX_W = $clog2(LONG_BITS);
  localparam logic [IDX_W-1:0] IDX_ONE        = IDX_W'(1);
  localparam logic [IDX_W-1:0] SHORT_LAST     = IDX_W'(SHORT_BITS - 1);
  localparam logic [IDX_W-1:0] LONG_LAST      = IDX_W'(LONG_BITS - 1);
  localparam logic [IDX_W-1:0] LONG_FIRST_KEEP = IDX_W'(LONG_SKIP);
  localparam logic [IDX_W-1:0] SHORT_CHK_END  = IDX_W'(SHORT_COV_END);
  localparam logic [IDX_W-1:0] LONG_CHK_END   = IDX_W'(LONG_COV_END);
  localparam logic [IDX_W-1:0] SHORT_CRC_STOP = IDX_W'(SHORT_COV_END + CRC_LEN);
  localparam logic [IDX_W-1:0] LONG_CRC_STOP  = IDX_W'(LONG_COV_END + CRC_LEN);

  cap_state_e         state_q;
  resp_kind_e         kind_q;
  logic [IDX_W-1:0]   idx_q;
  logic [TMO_W:0]     wait_q;
  logic               mism_q;

  logic               is_long, crc_checked;
  logic               sample, idle_tick, tmo_hit, finishing, bad_bit;
  logic               in_cov, in_crc;
  logic [IDX_W-1:0]   cur_idx, last_idx, cov_lo, cov_hi, crc_hi, keep_lo;

  always_comb begin
    is_long     = (kind_q == RK_LONG);
    crc_checked = (kind_q == RK_SHORT_CRC) || (kind_q == RK_LONG);
    last_idx    = is_long ? LONG_LAST       : SHORT_LAST;
    cov_lo      = is_long ? LONG_FIRST_KEEP : '0;
    cov_hi      = is_long ? LONG_CHK_END    : SHORT_CHK_END;
    crc_hi      = is_long ? LONG_CRC_STOP   : SHORT_CRC_STOP;
    keep_lo     = is_long ? LONG_FIRST_KEEP : '0;

    cmd_take  = (state_q == ST_IDLE) && cmd_sent;
    // the start bit is taken in the wait state as bit index 0
    sample    = bit_en && (((state_q == ST_WAIT) && !cmd_line) || (state_q == ST_RECV));
    cur_idx   = (state_q == ST_RECV) ? idx_q : '0;
    idle_tick = bit_en && (state_q == ST_WAIT) && cmd_line;
    tmo_hit   = idle_tick && ((wait_q + 1'b1) >= {1'b0, tmo_limit});

    in_cov    = (cur_idx >= cov_lo) && (cur_idx < cov_hi);
    in_crc    = (cur_idx >= cov_hi) && (cur_idx < crc_hi);
    crc_en    = sample && (in_cov || in_crc);
    crc_calc  = in_cov;
    bad_bit   = sample && in_crc && (cmd_line != crc_msb);
    pack_vld  = sample && (cur_idx >= keep_lo);
    finishing = sample && (state_q == ST_RECV) && (cur_idx == last_idx);

    set_crc   = finishing && crc_checked && (mism_q || bad_bit);
    set_tmo   = tmo_hit;
    set_end   = finishing || tmo_hit || (cmd_take && (resp_kind == 2'd0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= RK_NONE;
      idx_q   <= '0;
      wait_q  <= '0;
      mism_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cmd_sent) begin
            kind_q  <= resp_kind_e'(resp_kind);
            idx_q   <= '0;
            wait_q  <= '0;
            mism_q  <= 1'b0;
            state_q <= (resp_kind == 2'd0) ? ST_IDLE : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (sample) begin
            state_q <= ST_RECV;
            idx_q   <= IDX_ONE;
          end else if (tmo_hit) begin
            state_q <= ST_IDLE;
          end else if (idle_tick) begin
            wait_q  <= wait_q + 1'b1;
          end
        end
        ST_RECV: begin
          if (sample) begin
            if (bad_bit) mism_q <= 1'b1;
            if (finishing) state_q <= ST_IDLE;
            else           idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sd_resp_capture.sv
module sd_resp_capture
  import sd_resp_pkg::*;
#(
  parameter int               WORD_W     = 16,
  parameter int               FIFO_DEPTH = 8,
  parameter int               TMO_W      = 8,
  parameter logic [TMO_W-1:0] TMO_RESET  = 'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              cmd_line,
  input  logic              cmd_sent,
  input  logic [1:0]        resp_kind,
  input  logic              tmo_we,
  input  logic [TMO_W-1:0]  tmo_wdata,
  input  logic              stat_clr_we,
  input  logic [STAT_W-1:0] stat_clr_data,
  output logic [STAT_W-1:0] status_word,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data
);

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic [TMO_W-1:0]  tmo_limit;
  logic              cmd_take, resp_flush;
  logic              crc_en, crc_calc, crc_msb;
  logic              pack_vld, word_push, fifo_full;
  logic [WORD_W-1:0] word_data;
  logic [LVL_W-1:0]  fifo_level;
  logic              end_set, crc_set, tmo_set;
  logic              flag_end, flag_crc, flag_tmo;

  assign resp_flush = cmd_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo_limit <= TMO_RESET;
    else if (tmo_we) tmo_limit <= tmo_wdata;
  end

  sd_resp_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .cmd_line  (cmd_line),
    .cmd_sent  (cmd_sent),
    .resp_kind (resp_kind),
    .tmo_limit (tmo_limit),
    .crc_msb   (crc_msb),
    .cmd_take  (cmd_take),
    .crc_en    (crc_en),
    .crc_calc  (crc_calc),
    .pack_vld  (pack_vld),
    .set_end   (end_set),
    .set_crc   (crc_set),
    .set_tmo   (tmo_set)
  );

  sd_crc_serial #(.W(CRC_LEN), .POLY(7'h09)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cmd_take),
    .en    (crc_en),
    .calc  (crc_calc),
    .din   (cmd_line),
    .msb   (crc_msb)
  );

  sd_word_pack #(.WORD_W(WORD_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cmd_take),
    .bit_vld  (pack_vld),
    .din      (cmd_line),
    .word_out (word_data),
    .word_vld (word_push)
  );

  sd_word_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (resp_flush),
    .push      (word_push),
    .push_data (word_data),
    .out_ready (rsp_ready),
    .out_valid (rsp_valid),
    .out_data  (rsp_data),
    .full      (fifo_full),
    .level     (fifo_level)
  );

  // sticky flags: a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_end <= 1'b0;
      flag_crc <= 1'b0;
      flag_tmo <= 1'b0;
    end else begin
      flag_end <= end_set | (flag_end & ~(stat_clr_we & stat_clr_data[STAT_END_BIT]));
      flag_crc <= crc_set | (flag_crc & ~(stat_clr_we & stat_clr_data[STAT_CRC_BIT]));
      flag_tmo <= tmo_set | (flag_tmo & ~(stat_clr_we & stat_clr_data[STAT_TMO_BIT]));
    end
  end

  always_comb begin
    status_word               = '0;
    status_word[STAT_END_BIT] = flag_end;
    status_word[STAT_CRC_BIT] = flag_crc;
    status_word[STAT_TMO_BIT] = flag_tmo;
  end

endmodule

// File: rtl/sd_resp_capture_chk.sv
module sd_resp_capture_chk #(
  parameter int WORD_W     = 16,
  parameter int FIFO_DEPTH = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [15:0]                     status_word,
  input logic                            rsp_valid,
  input logic                            rsp_ready,
  input logic [WORD_W-1:0]               rsp_data,
  input logic                            word_push,
  input logic                            fifo_full,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
  input logic                            resp_flush,
  input logic                            cmd_take,
  input logic [1:0]                      resp_kind,
  input logic                            crc_set,
  input logic                            stat_clr_we,
  input logic [15:0]                     stat_clr_data
);

  p_tmo_with_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[1] && !$past(status_word[1])) |-> status_word[13]);

  p_none_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && resp_kind == 2'd0) |=> status_word[13]);

  p_hold_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !resp_flush) |=> (rsp_valid && $stable(rsp_data)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |-> !fifo_full);

  p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

  p_clear_crc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_we && stat_clr_data[5] && !crc_set) |=> !status_word[5]);

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & 16'hDFDD) == 16'h0000);

endmodule

bind sd_resp_capture sd_resp_capture_chk #(
  .WORD_W     (WORD_W),
  .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .status_word   (status_word),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .word_push     (word_push),
  .fifo_full     (fifo_full),
  .fifo_level    (fifo_level),
  .resp_flush    (resp_flush),
  .cmd_take      (cmd_take),
  .resp_kind     (resp_kind),
  .crc_set       (crc_set),
  .stat_clr_we   (stat_clr_we),
  .stat_clr_data (stat_clr_data)
);

// File: tb/sd_resp_capture_tb_top.sv
module sd_resp_capture_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        cmd_line = 1'b1;
  logic        cmd_sent = 1'b0;
  logic [1:0]  resp_kind = 2'd0;
  logic        tmo_we = 1'b0;
  logic [7:0]  tmo_wdata = 8'd0;
  logic        stat_clr_we = 1'b0;
  logic [15:0] stat_clr_data = 16'd0;
  logic [15:0] status_word;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sd_resp_capture dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en        (bit_en),
    .cmd_line      (cmd_line),
    .cmd_sent      (cmd_sent),
    .resp_kind     (resp_kind),
    .tmo_we        (tmo_we),
    .tmo_wdata     (tmo_wdata),
    .stat_clr_we   (stat_clr_we),
    .stat_clr_data (stat_clr_data),
    .status_word   (status_word),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_data      (rsp_data)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [127:0] v, input int n);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      fb = v[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  task automatic tick_bit(input logic b);
    @(negedge clk);
    cmd_line = b;
    bit_en   = 1'b1;
    @(negedge clk);
    bit_en   = 1'b0;
    cmd_line = 1'b1;
  endtask

  task automatic send_cmd(input logic [1:0] kind);
    @(negedge clk);
    resp_kind = kind;
    cmd_sent  = 1'b1;
    @(negedge clk);
    cmd_sent  = 1'b0;
  endtask

  task automatic clear_stat(input logic [15:0] mask);
    @(negedge clk);
    stat_clr_we   = 1'b1;
    stat_clr_data = mask;
    @(negedge clk);
    stat_clr_we   = 1'b0;
    stat_clr_data = '0;
  endtask

  task automatic read_word(input string tag, output logic [15:0] w);
    int n;
    n = 0;
    while (!rsp_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    check({tag, " valid"}, {63'd0, rsp_valid}, 64'd1);
    w = rsp_data;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  // 48-bit reply: start 0, direction 0, index, argument, crc7, end 1
  task automatic send_short(input logic [5:0] idx, input logic [31:0] arg,
                            input logic [6:0] crc_flip, output logic [47:0] r);
    logic [6:0] c;
    r = {1'b0, 1'b0, idx, arg, 7'd0, 1'b1};
    c = crc7({80'd0, r[47:0]} >> 8, 40) ^ crc_flip;
    r[7:1] = c;
    tick_bit(1'b1);
    tick_bit(1'b1);
    for (int i = 47; i >= 0; i--) tick_bit(r[i]);
    @(negedge clk);
  endtask

  // 136-bit reply: start, direction, six ones, 120 content bits, crc7, end
  task automatic send_long(input logic [119:0] content, input logic [6:0] crc_flip,
                           input logic [119:0] content_flip, output logic [135:0] r);
    logic [6:0] c;
    c = crc7({8'd0, content}, 120) ^ crc_flip;
    r = {1'b0, 1'b0, 6'h3F, content ^ content_flip, c, 1'b1};
    tick_bit(1'b1);
    for (int i = 135; i >= 0; i--) tick_bit(r[i]);
    @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0]  rs;
    logic [135:0] rl;
    logic [15:0]  w0, w1, w2, wl;
    logic [31:0]  arg;
    logic [119:0] cont;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 status after reset", {48'd0, status_word}, 64'd0);
    check("R11 valid after reset", {63'd0, rsp_valid}, 64'd0);

    // R1 type 0
    send_cmd(2'd0);
    check("R1 none end flag", {48'd0, status_word}, 64'h2000);
    check("R1 none no words", {63'd0, rsp_valid}, 64'd0);
    clear_stat(16'h2022);
    check("R8 clear all", {48'd0, status_word}, 64'd0);

    // R2 R4 R7 sweep of type 1 over every index
    for (int j = 0; j < 64; j++) begin
      arg = (j * 32'h9E3779B1) ^ {j[7:0], 24'h5A0F3C};
      send_cmd(2'd1);
      send_short(j[5:0], arg, 7'd0, rs);
      check("R7 R5 short good status", {48'd0, status_word}, 64'h2000);
      read_word("R2 w0", w0);
      read_word("R2 w1", w1);
      read_word("R2 w2", w2);
      check("R2 word0", {48'd0, w0}, {48'd0, rs[47:32]});
      check("R2 word1", {48'd0, w1}, {48'd0, rs[31:16]});
      check("R2 word2", {48'd0, w2}, {48'd0, rs[15:0]});
      check("R2 rebuilt argument",
            {32'd0, ({16'd0, w0} << 24) | ({16'd0, w1} << 8) | ({16'd0, w2} >> 8)},
            {32'd0, arg});
      check("R2 three words only", {63'd0, rsp_valid}, 64'd0);
      clear_stat(16'h2000);
    end

    // R4 R5 each corrupted check bit, type 1 flags, type 3 does not
    for (int k = 0; k < 7; k++) begin
      send_cmd(2'd1);
      send_short(6'd17, 32'hC0FFEE00 + k, 7'd1 << k, rs);
      check("R4 type1 crc bit error", {48'd0, status_word}, 64'h2020);
      clear_stat(16'h2020);
      send_cmd(2'd3);
      send_short(6'd41, 32'h12340000 + k, 7'd1 << k, rs);
      check("R5 type3 crc ignored", {48'd0, status_word}, 64'h2000);
      read_word("R5 w0", w0);
      check("R5 type3 word0", {48'd0, w0}, {48'd0, rs[47:32]});
      clear_stat(16'h2000);
    end

    // R3 R4 long replies
    for (int j = 0; j < 6; j++) begin
      cont = {j[7:0] * 8'h3B, (j + 1) * 32'h8F1BBCDC, 32'hDEADBEEF ^ (j * 32'h01010101),
              32'h0BADF00D + j, 24'h55AA33};
      send_cmd(2'd2);
      send_long(cont, 7'd0, 120'd0, rl);
      check("R3 long good status", {48'd0, status_word}, 64'h2000);
      for (int k = 0; k < 8; k++) begin
        read_word("R3 long", wl);
        check("R3 long word", {48'd0, wl}, {48'd0, rl[127 - 16*k -: 16]});
      end
      check("R3 eight words only", {63'd0, rsp_valid}, 64'd0);
      clear_stat(16'h2000);
      send_cmd(2'd2);
      send_long(cont, 7'd1 << (j % 7), 120'd0, rl);
      check("R4 long crc field error", {48'd0, status_word}, 64'h2020);
      clear_stat(16'h2020);
      send_cmd(2'd2);
      send_long(cont, 7'd0, 120'd1 << (j * 19), rl);
      check("R4 long content error", {48'd0, status_word}, 64'h2020);
      clear_stat(16'h2020);
    end

    // R6 default limit 255
    send_cmd(2'd1);
    for (int i = 0; i < 254; i++) tick_bit(1'b1);
    @(negedge clk);
    check("R6 no timeout at 254", {48'd0, status_word}, 64'd0);
    tick_bit(1'b1);
    @(negedge clk);
    check("R6 timeout at 255", {48'd0, status_word}, 64'h2002);
    check("R6 no words on timeout", {63'd0, rsp_valid}, 64'd0);
    clear_stat(16'h2002);

    // R6 programmed limit 5
    @(negedge clk);
    tmo_we = 1'b1; tmo_wdata = 8'd5;
    @(negedge clk);
    tmo_we = 1'b0;
    send_cmd(2'd3);
    for (int i = 0; i < 4; i++) tick_bit(1'b1);
    @(negedge clk);
    check("R6 no timeout at 4", {48'd0, status_word}, 64'd0);
    tick_bit(1'b1);
    @(negedge clk);
    check("R6 timeout at 5", {48'd0, status_word}, 64'h2002);
    clear_stat(16'h2002);

    // R10 cmd_sent during wait is ignored, type 1 stays in force
    send_cmd(2'd1);
    tick_bit(1'b1);
    send_cmd(2'd0);
    @(negedge clk);
    check("R10 mid capture command ignored", {48'd0, status_word}, 64'd0);
    send_short(6'd9, 32'hA5A50F0F, 7'h10, rs);
    check("R10 type kept crc checked", {48'd0, status_word}, 64'h2020);

    // R8 selective clear
    clear_stat(16'h0002);
    check("R8 clear absent bit", {48'd0, status_word}, 64'h2020);
    clear_stat(16'h0020);
    check("R8 clear crc only", {48'd0, status_word}, 64'h2000);
    clear_stat(16'h0000);
    check("R8 zero mask", {48'd0, status_word}, 64'h2000);
    clear_stat(16'h2000);
    check("R8 clear end", {48'd0, status_word}, 64'd0);

    // R9 back-pressure and discard
    repeat (10) @(negedge clk);
    check("R9 held valid", {63'd0, rsp_valid}, 64'd1);
    check("R9 held head", {48'd0, rsp_data}, {48'd0, rs[47:32]});
    read_word("R9 pop", w0);
    check("R9 next word", {48'd0, rsp_data}, {48'd0, rs[31:16]});
    send_cmd(2'd0);
    check("R9 discard on new command", {63'd0, rsp_valid}, 64'd0);
    clear_stat(16'h2000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule